// File: doc/BRIEF.md
# Command Object Interpreter with Register Access

The block takes a payload that has already been framed and checksum-verified, and reads it from a receive buffer one byte per cycle. It treats the payload as a chain of objects. Each object is a command ID, a size byte and that many argument bytes.

The interpreter works in two phases. The first phase parses and validates every object. It collects the write target, the location of the write data, and the read window. If the whole packet is sound, the second phase runs. It first performs the register writes and then streams the requested register bytes out on a read-back port. In both cases the block then presents one status code on a valid/ready result port, for use by the reply framer.

Any fault stops the parse and the block reports its numeric code. On a fault, no register is changed and no read-back byte is sent.

Top module: `cmd_interp`

## Requirements
- R1: ID 1 (write, size 1: target address) and ID 10 (data, size at least 1), in either order, store the data bytes into consecutive registers starting at the target address, and yield status 0.
- R2: ID 2 (read, size 2: start address then byte count) emits the count bytes of consecutive registers on the read-back port, one per cycle. This happens after all writes of the same packet, and the status is 0.
- R3: An object with an ID other than 1, 2 or 10 yields status 4.
- R4: Status 7 is returned in these cases: fewer than two bytes remain for an object header, an object's declared size runs past the payload length, or a write object has no data object.
- R5: Status 8 is returned when a write object's size is not 1, a read object's size is not 2, or a data object's size is 0.
- R6: Status 11 is returned when an ID appears twice in one packet, or when a data object appears without a write object.
- R7: Status 9 is returned when a write or read range extends past the last register (address plus length greater than NREG). A range ending exactly at the last register is accepted.
- R8: Whenever the status is non-zero, no register write and no read-back byte occurs for that packet.
- R9: Objects are judged in payload order, and the first faulty one decides the status. Within one object the checks run in this order: truncation, unknown ID, duplicate, size. Packet-level checks run after the last object in this order: data without write (11), write without data (7), write range (9), read range (9).
- R10: The result valid stays high with a stable status until ready is seen, then drops. A start pulse while a packet is being processed or held is ignored.
- R11: An empty payload yields status 0 with no writes and no read-back bytes.
- R12: During and directly after reset, result valid, register write enable and read-back valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Payload in buffer is ready to interpret |
| len_i | input | BUF_AW | Payload length in bytes |
| buf_addr_o | output | BUF_AW | Receive buffer byte address |
| buf_data_i | input | 8 | Receive buffer byte at buf_addr_o (same cycle) |
| reg_we_o | output | 1 | Register write enable |
| reg_addr_o | output | $clog2(NREG) | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data at reg_addr_o (same cycle) |
| rb_valid_o | output | 1 | Read-back byte valid |
| rb_data_o | output | 8 | Read-back byte |
| res_valid_o | output | 1 | Result status valid |
| res_ready_i | input | 1 | Reply framer accepts the result |
| res_status_o | output | 8 | Result status code |

## Verification
The bench builds the block with its defaults: NREG of 16 and an 8-bit buffer address. With 16 registers, both sides of the range limit can be reached with payloads of only a few bytes: a two-byte read at 14 fits, while one at 15, or a three-byte write at 14, does not. The 8-bit length lets one packet carry data, write and read objects together, so write-before-read ordering and the atomic rejection of a packet whose earlier objects were valid can both be observed.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_SZ, S_ARG, S_POST, S_WR, S_RD, S_DONE
  } state_e;

  localparam logic [7:0] ID_WR  = 8'd1;
  localparam logic [7:0] ID_RD  = 8'd2;
  localparam logic [7:0] ID_DAT = 8'd10;

  localparam logic [7:0] ST_OK     = 8'd0;
  localparam logic [7:0] ST_BADCMD = 8'd4;
  localparam logic [7:0] ST_SHORT  = 8'd7;
  localparam logic [7:0] ST_SIZE   = 8'd8;
  localparam logic [7:0] ST_NOREG  = 8'd9;
  localparam logic [7:0] ST_TYPE   = 8'd11;
endpackage

// File: rtl/cmd_obj_check.sv
module cmd_obj_check
  import cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] len_i,
  input  logic [7:0]    id_i,
  input  logic [7:0]    sz_i,
  input  logic          seen_wr_i,
  input  logic          seen_rd_i,
  input  logic          seen_dat_i,
  output logic          err_o,
  output logic [7:0]    code_o
);
  localparam int SW = AW + 9;

  logic [SW-1:0] end_pos;
  logic known, dup, bad_sz;

  assign end_pos = SW'(ptr_i) + SW'(2) + SW'(sz_i);
  assign known   = (id_i == ID_WR) || (id_i == ID_RD) || (id_i == ID_DAT);
  assign dup     = (id_i == ID_WR && seen_wr_i) || (id_i == ID_RD && seen_rd_i) ||
                   (id_i == ID_DAT && seen_dat_i);
  assign bad_sz  = (id_i == ID_WR && sz_i != 8'd1) || (id_i == ID_RD && sz_i != 8'd2) ||
                   (id_i == ID_DAT && sz_i == 8'd0);

  always_comb begin
    err_o  = 1'b1;
    code_o = ST_OK;
    if (end_pos > SW'(len_i)) code_o = ST_SHORT;
    else if (!known)          code_o = ST_BADCMD;
    else if (dup)             code_o = ST_TYPE;
    else if (bad_sz)          code_o = ST_SIZE;
    else                      err_o  = 1'b0;
  end
endmodule

// File: rtl/cmd_range_check.sv
module cmd_range_check
  import cmd_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic       seen_wr_i,
  input  logic       seen_rd_i,
  input  logic       seen_dat_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_len_i,
  input  logic [7:0] rd_addr_i,
  input  logic [7:0] rd_len_i,
  output logic       err_o,
  output logic [7:0] code_o
);
  localparam int EW = 10;
  localparam logic [EW-1:0] LIM = EW'(NREG);

  logic [EW-1:0] wr_end, rd_end;
  assign wr_end = EW'(wr_addr_i) + EW'(wr_len_i);
  assign rd_end = EW'(rd_addr_i) + EW'(rd_len_i);

  always_comb begin
    err_o  = 1'b1;
    code_o = ST_OK;
    if (seen_dat_i && !seen_wr_i)          code_o = ST_TYPE;
    else if (seen_wr_i && !seen_dat_i)     code_o = ST_SHORT;
    else if (seen_wr_i && wr_end > LIM)    code_o = ST_NOREG;
    else if (seen_rd_i && rd_end > LIM)    code_o = ST_NOREG;
    else                                   err_o  = 1'b0;
  end
endmodule

// File: rtl/cmd_interp.sv
module cmd_interp
  import cmd_pkg::*;
#(
  parameter int BUF_AW = 8,
  parameter int NREG   = 16,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BUF_AW-1:0] len_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i,
  output logic              rb_valid_o,
  output logic [7:0]        rb_data_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [7:0]        res_status_o
);
  state_e            state_q;
  logic [BUF_AW-1:0] ptr_q, len_q, dat_off_q;
  logic [7:0]        id_q, cnt_q, wr_addr_q, dat_len_q, rd_start_q, rd_cnt_q, status_q;
  logic              seen_wr_q, seen_rd_q, seen_dat_q;

  logic       oc_err, rc_err;
  logic [7:0] oc_code, rc_code;

  // In S_SZ the buffer presents the size byte of the current object
  cmd_obj_check #(.AW(BUF_AW)) u_obj (
    .ptr_i(ptr_q), .len_i(len_q), .id_i(id_q), .sz_i(buf_data_i),
    .seen_wr_i(seen_wr_q), .seen_rd_i(seen_rd_q), .seen_dat_i(seen_dat_q),
    .err_o(oc_err), .code_o(oc_code)
  );

  cmd_range_check #(.NREG(NREG)) u_rng (
    .seen_wr_i(seen_wr_q), .seen_rd_i(seen_rd_q), .seen_dat_i(seen_dat_q),
    .wr_addr_i(wr_addr_q), .wr_len_i(dat_len_q),
    .rd_addr_i(rd_start_q), .rd_len_i(rd_cnt_q),
    .err_o(rc_err), .code_o(rc_code)
  );

  always_comb begin
    unique case (state_q)
      S_SZ:    buf_addr_o = ptr_q + BUF_AW'(1);
      S_WR:    buf_addr_o = dat_off_q + BUF_AW'(cnt_q);
      default: buf_addr_o = ptr_q;
    endcase
    reg_we_o     = (state_q == S_WR);
    reg_addr_o   = (state_q == S_WR) ? REG_AW'(wr_addr_q + cnt_q) : REG_AW'(rd_start_q + cnt_q);
    reg_wdata_o  = buf_data_i;
    rb_valid_o   = (state_q == S_RD) && (rd_cnt_q != 8'd0);
    rb_data_o    = reg_rdata_i;
    res_valid_o  = (state_q == S_DONE);
    res_status_o = status_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      ptr_q      <= '0;
      len_q      <= '0;
      dat_off_q  <= '0;
      id_q       <= '0;
      cnt_q      <= '0;
      wr_addr_q  <= '0;
      dat_len_q  <= '0;
      rd_start_q <= '0;
      rd_cnt_q   <= '0;
      status_q   <= ST_OK;
      seen_wr_q  <= 1'b0;
      seen_rd_q  <= 1'b0;
      seen_dat_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          ptr_q      <= '0;
          len_q      <= len_i;
          status_q   <= ST_OK;
          seen_wr_q  <= 1'b0;
          seen_rd_q  <= 1'b0;
          seen_dat_q <= 1'b0;
          state_q    <= S_ID;
        end
        S_ID: begin
          if (ptr_q == len_q) state_q <= S_POST;
          else if ((len_q - ptr_q) < BUF_AW'(2)) begin
            status_q <= ST_SHORT;
            state_q  <= S_DONE;
          end else begin
            id_q    <= buf_data_i;
            state_q <= S_SZ;
          end
        end
        S_SZ: begin
          if (oc_err) begin
            status_q <= oc_code;
            state_q  <= S_DONE;
          end else if (id_q == ID_DAT) begin
            seen_dat_q <= 1'b1;
            dat_off_q  <= ptr_q + BUF_AW'(2);
            dat_len_q  <= buf_data_i;
            ptr_q      <= ptr_q + BUF_AW'(2) + BUF_AW'(buf_data_i);
            state_q    <= S_ID;
          end else begin
            if (id_q == ID_WR) seen_wr_q <= 1'b1;
            else               seen_rd_q <= 1'b1;
            ptr_q   <= ptr_q + BUF_AW'(2);
            cnt_q   <= '0;
            state_q <= S_ARG;
          end
        end
        S_ARG: begin
          ptr_q <= ptr_q + BUF_AW'(1);
          if (id_q == ID_WR) begin
            wr_addr_q <= buf_data_i;
            state_q   <= S_ID;
          end else if (cnt_q == 8'd0) begin
            rd_start_q <= buf_data_i;
            cnt_q      <= 8'd1;
          end else begin
            rd_cnt_q <= buf_data_i;
            state_q  <= S_ID;
          end
        end
        S_POST: begin
          cnt_q <= '0;
          if (rc_err) begin
            status_q <= rc_code;
            state_q  <= S_DONE;
          end else if (seen_wr_q) state_q <= S_WR;
          else if (seen_rd_q)     state_q <= S_RD;
          else                    state_q <= S_DONE;
        end
        S_WR: begin
          cnt_q <= cnt_q + 8'd1;
          if (cnt_q == dat_len_q - 8'd1) begin
            cnt_q   <= '0;
            state_q <= seen_rd_q ? S_RD : S_DONE;
          end
        end
        S_RD: begin
          cnt_q <= cnt_q + 8'd1;
          if (rd_cnt_q == 8'd0 || cnt_q == rd_cnt_q - 8'd1) state_q <= S_DONE;
        end
        S_DONE: if (res_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_interp_chk.sv
module cmd_interp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_o,
  input logic       rb_valid_o,
  input logic       res_valid_o,
  input logic       res_ready_i,
  input logic [7:0] res_status_o
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_status_o));

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_ready_i |=> !res_valid_o);

  // codes limited to the documented set (R3..R7)
  p_code_known_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_status_o == 8'd0 || res_status_o == 8'd4 || res_status_o == 8'd7 ||
                     res_status_o == 8'd8 || res_status_o == 8'd9 || res_status_o == 8'd11));

  p_we_alone_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !rb_valid_o && !res_valid_o);

  p_read_after_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_o |=> !reg_we_o);

  p_atomic_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) && res_status_o != 8'd0 |-> !$past(reg_we_o) && !$past(rb_valid_o));
endmodule

bind cmd_interp cmd_interp_chk u_chk (.*);

// File: tb/cmd_interp_test.sv
module cmd_interp_test;
  localparam int BUF_AW = 8;
  localparam int NREG   = 16;
  localparam int RAW    = $clog2(NREG);

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  len;
    logic [63:0] pay;
    logic [7:0]  st;
    logic [7:0]  nwe;
    logic [7:0]  nrb;
    logic [7:0]  b0;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  8'd4, 64'h02020001_00000000, 8'd0,  8'd0, 8'd1, 8'h40}, // R2 read reg0
    '{8'd3,  8'd3, 64'h070100_0000000000, 8'd4,  8'd0, 8'd0, 8'h00}, // R3 unknown id
    '{8'd4,  8'd3, 64'h020200_0000000000, 8'd7,  8'd0, 8'd0, 8'h00}, // R4 body cut
    '{8'd4,  8'd1, 64'h02_00000000000000, 8'd7,  8'd0, 8'd0, 8'h00}, // R4 header cut
    '{8'd6,  8'd3, 64'h0A0155_0000000000, 8'd11, 8'd0, 8'd0, 8'h00}, // R6 data alone
    '{8'd4,  8'd3, 64'h010103_0000000000, 8'd7,  8'd0, 8'd0, 8'h00}, // R4 write no data
    '{8'd5,  8'd4, 64'h01020304_00000000, 8'd8,  8'd0, 8'd0, 8'h00}, // R5 write size
    '{8'd6,  8'd8, 64'h02020001_02020001, 8'd11, 8'd0, 8'd0, 8'h00}, // R6 duplicate
    '{8'd7,  8'd4, 64'h02020F02_00000000, 8'd9,  8'd0, 8'd0, 8'h00}, // R7 read past end
    '{8'd7,  8'd8, 64'h01010E0A_03010203, 8'd9,  8'd0, 8'd0, 8'h00}, // R7 write past end
    '{8'd1,  8'd7, 64'h0101040A_02AABB00, 8'd0,  8'd2, 8'd0, 8'h00}, // R1 write 4,5
    '{8'd5,  8'd2, 64'h0A00_000000000000, 8'd8,  8'd0, 8'd0, 8'h00}, // R5 empty data
    '{8'd9,  8'd6, 64'h02020001_09000000, 8'd4,  8'd0, 8'd0, 8'h00}, // R9/R8 later fault
    '{8'd11, 8'd0, 64'h0,                 8'd0,  8'd0, 8'd0, 8'h00}, // R11 empty
    '{8'd7,  8'd4, 64'h02020E02_00000000, 8'd0,  8'd0, 8'd2, 8'h4E}, // R7 edge fits, R8 reg14 kept
    '{8'd9,  8'd3, 64'h090500_0000000000, 8'd7,  8'd0, 8'd0, 8'h00}  // R9 cut before unknown
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [BUF_AW-1:0] len_i = '0;
  logic [BUF_AW-1:0] buf_addr_o;
  logic [7:0]        buf_data_i;
  logic              reg_we_o;
  logic [RAW-1:0]    reg_addr_o;
  logic [7:0]        reg_wdata_o;
  logic [7:0]        reg_rdata_i;
  logic              rb_valid_o;
  logic [7:0]        rb_data_o;
  logic              res_valid_o;
  logic              res_ready_i = 1'b0;
  logic [7:0]        res_status_o;

  logic [7:0] mem [256];
  logic [7:0] rf  [NREG];

  int n_chk = 0, n_bad = 0;
  int got_st, got_nwe, got_nrb;
  logic [7:0] got_rb [16];

  always #5 clk = ~clk;

  assign buf_data_i  = mem[buf_addr_o];
  assign reg_rdata_i = rf[reg_addr_o];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h40 + 8'(i);
    end else if (reg_we_o) rf[reg_addr_o] <= reg_wdata_o;
  end

  cmd_interp #(.BUF_AW(BUF_AW), .NREG(NREG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .len_i(len_i),
    .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
    .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i), .rb_valid_o(rb_valid_o), .rb_data_o(rb_data_o),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_status_o(res_status_o)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic run_pkt(input int n, input int hold);
    int wd;
    got_nwe = 0;
    got_nrb = 0;
    @(negedge clk);
    len_i   = BUF_AW'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wd = 0;
    while (!res_valid_o && wd < 1000) begin
      if (reg_we_o) got_nwe++;
      if (rb_valid_o) begin
        if (got_nrb < 16) got_rb[got_nrb] = rb_data_o;
        got_nrb++;
      end
      @(negedge clk);
      wd++;
    end
    if (wd >= 1000) chk(1'b0, "R10 result timeout", 0, 1);
    got_st = int'(res_status_o);
    for (int h = 0; h < hold; h++) begin
      start_i = (h == 0);
      @(negedge clk);
      start_i = 1'b0;
      chk(res_valid_o == 1'b1, "R10 valid held", int'(res_valid_o), 1);
      chk(int'(res_status_o) == got_st, "R10 status stable", int'(res_status_o), got_st);
    end
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10 watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R12 during reset
    chk(!res_valid_o && !reg_we_o && !rb_valid_o, "R12 in reset",
        int'({res_valid_o, reg_we_o, rb_valid_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid_o && !reg_we_o && !rb_valid_o, "R12 after reset",
        int'({res_valid_o, reg_we_o, rb_valid_o}), 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[v].req, v);
      for (int k = 0; k < 8; k++) mem[k] = VECS[v].pay[63-8*k -: 8];
      run_pkt(int'(VECS[v].len), 0);
      chk(got_st == int'(VECS[v].st), {tag, " status"}, got_st, int'(VECS[v].st));
      chk(got_nwe == int'(VECS[v].nwe), {tag, " writes"}, got_nwe, int'(VECS[v].nwe));
      chk(got_nrb == int'(VECS[v].nrb), {tag, " readback"}, got_nrb, int'(VECS[v].nrb));
      if (VECS[v].nrb != 0)
        chk(got_rb[0] == VECS[v].b0, {tag, " first byte"}, int'(got_rb[0]), int'(VECS[v].b0));
    end

    // R8: the rejected write at 14 left reg 15 intact
    chk(rf[15] == 8'h4F, "R8 reg15 kept", int'(rf[15]), 8'h4F);

    // R1/R2: data before write, then read spans old and new values
    mem[0] = 8'h0A; mem[1] = 8'h02; mem[2] = 8'hC1; mem[3] = 8'hC2;
    mem[4] = 8'h01; mem[5] = 8'h01; mem[6] = 8'h05;
    mem[7] = 8'h02; mem[8] = 8'h02; mem[9] = 8'h04; mem[10] = 8'h03;
    run_pkt(11, 0);
    chk(got_st == 0, "R1 combo status", got_st, 0);
    chk(got_nwe == 2, "R1 combo writes", got_nwe, 2);
    chk(got_nrb == 3, "R2 combo count", got_nrb, 3);
    chk(got_rb[0] == 8'hAA, "R2 byte0", int'(got_rb[0]), 8'hAA);
    chk(got_rb[1] == 8'hC1, "R2 byte1 after write", int'(got_rb[1]), 8'hC1);
    chk(got_rb[2] == 8'hC2, "R2 byte2 after write", int'(got_rb[2]), 8'hC2);

    // R10: delayed ready with a stray start while holding
    mem[0] = 8'h02; mem[1] = 8'h02; mem[2] = 8'h00; mem[3] = 8'h01;
    run_pkt(4, 3);
    chk(got_st == 0, "R10 held status", got_st, 0);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      chk(!res_valid_o && !rb_valid_o, "R10 start ignored", int'(res_valid_o), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule